// File: doc/BRIEF.md
# Front-End Fast-Command Decoder

This block sits in a front-end chip behind the optical link and turns the 24-bit fast-control word into timed control strobes. The word comes in one bunch-crossing cycle at a time, split across a double-data-rate pair of 12-bit half-words. The block joins the two halves into one word and decodes the command bits it carries.

Commands are sent a fixed number of cycles before the crossing they refer to. Each command therefore goes through its own delay line, which software sets from 0 to 31 cycles, so that it lands on the intended crossing. The block also runs a local bunch counter that only the orbit-marker command (or the chip reset) can reset. It compares that counter with the bunch number carried in every word and keeps a sticky flag when the two disagree. A sync command takes effect only after it has persisted. A snapshot command freezes the counter and the flag into holding registers for later readout.

Top module: `fcmd_decoder`

## Requirements
- R1: The upper half (word bits 23:12) is sampled on `rise_half_i` at a rising clock edge. The lower half (bits 11:0) is sampled on `fall_half_i` at the following falling edge. The joined word is registered at the next rising edge, and the decode logic works from that register.
- R2: Word layout: bits 11:0 bunch number, 15:12 calibration type, 16 veto, 17 front-end reset, 18 bunch-counter reset, 19 header-only, 20 zero-suppression-off, 21 snapshot, 22 sync, 23 event-number reset.
- R3: Writing `cfg_dly_i` with `cfg_we_i` high sets the delay of channel `cfg_sel_i`, where 0 veto, 1 front-end reset, 2 header-only, 3 zero-suppression-off, 4 snapshot, 5 sync, 6 event-number reset, 7 calibration type. A command with delay d shows on its output d cycles after the cycle in which its word is in the register; d = 0 means the same cycle.
- R4: `cal_type_o` shows the 4-bit calibration type of the word, delayed by channel 7. A zero value means that no calibration is requested.
- R5: The front-end reset bit drives `fe_rst_o` for one cycle per asserted word. It has no effect on the bunch counter.
- R6: The bunch counter advances by one each cycle and wraps from ORBIT_LEN-1 to 0. After a word with the bunch-counter-reset bit set is registered, the counter reads 1 on the next cycle. Only that bit and `rst_ni` reset the counter.
- R7: The first counter-reset word arms the check. From then on, the received bunch number of each registered word must equal 0 for a counter-reset word and the counter value otherwise. A difference sets `mismatch_o` on the next cycle. `clr_mm_i` clears the flag unless a new difference occurs in the same cycle.
- R8: `sync_o` is high only on the third and later consecutive cycles in which the delayed sync bit is high.
- R9: While the delayed snapshot strobe `snap_o` is high, the next clock edge copies the counter into `snap_bx_o` and the flag into `snap_mm_o`.
- R10: During reset all outputs are 0 and all delays are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rise_half_i | input | 12 | Upper half-word, rising-edge sampled |
| fall_half_i | input | 12 | Lower half-word, falling-edge sampled |
| cfg_we_i | input | 1 | Delay register write strobe |
| cfg_sel_i | input | 3 | Channel selected for write |
| cfg_dly_i | input | 5 | Delay value to write |
| clr_mm_i | input | 1 | Clears the mismatch flag |
| veto_o | output | 1 | Delayed veto |
| fe_rst_o | output | 1 | Delayed front-end reset pulse |
| hdr_only_o | output | 1 | Delayed header-only |
| nzs_o | output | 1 | Delayed zero-suppression-off |
| snap_o | output | 1 | Delayed snapshot strobe |
| evid_rst_o | output | 1 | Delayed event-number reset |
| cal_type_o | output | 4 | Delayed calibration type |
| sync_o | output | 1 | Filtered sync |
| bx_cnt_o | output | 12 | Local bunch counter |
| mismatch_o | output | 1 | Sticky bunch-number mismatch |
| snap_bx_o | output | 12 | Counter captured on snapshot |
| snap_mm_o | output | 1 | Flag captured on snapshot |

## Verification
Four things are checked on every cycle by properties: the counter's step-and-wrap and its reload to 1 after a reset word, the flag staying set until cleared, the need for two earlier sync cycles before `sync_o`, and what the snapshot registers capture. Several things can only be shown by the bench's scenarios, which compare against a model: the joining of the DDR halves, the exact per-channel delay including the extremes 0 and 31, arming of the check on the first reset word, and the effect of injected bunch-number errors. The same holds for sync runs of one, two and three cycles and for front-end resets leaving the counter alone.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int unsigned HALF_W    = 12;
  localparam int unsigned WORD_W    = 2 * HALF_W;
  localparam int unsigned BX_W      = 12;
  localparam int unsigned CAL_W     = 4;
  localparam int unsigned N_BIT_CMD = 7;
  localparam int unsigned N_CH      = N_BIT_CMD + 1;
  localparam int unsigned SEL_W     = $clog2(N_CH);

  // channel indices, shared by cfg_sel_i and the delay bank
  localparam int unsigned CH_VETO = 0;
  localparam int unsigned CH_FE   = 1;
  localparam int unsigned CH_HDR  = 2;
  localparam int unsigned CH_NZS  = 3;
  localparam int unsigned CH_SNAP = 4;
  localparam int unsigned CH_SYNC = 5;
  localparam int unsigned CH_EVID = 6;
  localparam int unsigned CH_CAL  = 7;

  typedef struct packed {
    logic             evid_rst;
    logic             sync;
    logic             snap;
    logic             nzs;
    logic             hdr_only;
    logic             bx_rst;
    logic             fe_rst;
    logic             veto;
    logic [CAL_W-1:0] cal;
    logic [BX_W-1:0]  bx;
  } fcmd_word_t;
endpackage

// File: rtl/fcmd_ddr_rx.sv
module fcmd_ddr_rx #(
  parameter int unsigned HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] rise_i,
  input  logic [HW-1:0] fall_i,
  output logic [2*HW-1:0] word_o
);
  logic [HW-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else         hi_q <= rise_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else         lo_q <= fall_i;
  end

  // both halves of one word are held when the next rising edge arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= {hi_q, lo_q};
  end
endmodule

// File: rtl/fcmd_delay_line.sv
module fcmd_delay_line #(
  parameter int unsigned W    = 1,
  parameter int unsigned DMAX = 31,
  localparam int unsigned SW  = $clog2(DMAX + 1),
  localparam int unsigned AW  = (DMAX > 1) ? $clog2(DMAX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] sel_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] sr [DMAX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DMAX; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d_i;
      for (int i = 1; i < DMAX; i++) sr[i] <= sr[i-1];
    end
  end

  always_comb begin
    int unsigned k;
    k = int'(sel_i);
    if (k > DMAX) k = DMAX;
    q_o = (k == 0) ? d_i : sr[AW'(k - 1)];
  end
endmodule

// File: rtl/fcmd_bx_track.sv
module fcmd_bx_track #(
  parameter int unsigned BX_W      = 12,
  parameter int unsigned ORBIT_LEN = 3564
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BX_W-1:0] rx_bx_i,
  input  logic            bx_rst_i,
  input  logic            clr_i,
  output logic [BX_W-1:0] cnt_o,
  output logic            mm_o
);
  localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

  logic            armed_q;
  logic [BX_W-1:0] expect_bx;
  logic            err;

  assign expect_bx = bx_rst_i ? '0 : cnt_o;
  assign err       = (armed_q || bx_rst_i) && (rx_bx_i != expect_bx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      armed_q <= 1'b0;
      mm_o    <= 1'b0;
    end else begin
      if (bx_rst_i)          cnt_o <= BX_W'(1);
      else if (cnt_o == LAST) cnt_o <= '0;
      else                   cnt_o <= cnt_o + 1'b1;
      if (bx_rst_i) armed_q <= 1'b1;
      if (err)        mm_o <= 1'b1;
      else if (clr_i) mm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int unsigned ORBIT_LEN = 3564,
  parameter int unsigned MAX_DLY   = 31,
  localparam int unsigned DLY_W    = $clog2(MAX_DLY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] rise_half_i,
  input  logic [HALF_W-1:0] fall_half_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [DLY_W-1:0]  cfg_dly_i,
  input  logic              clr_mm_i,
  output logic              veto_o,
  output logic              fe_rst_o,
  output logic              hdr_only_o,
  output logic              nzs_o,
  output logic              snap_o,
  output logic              evid_rst_o,
  output logic [CAL_W-1:0]  cal_type_o,
  output logic              sync_o,
  output logic [BX_W-1:0]   bx_cnt_o,
  output logic              mismatch_o,
  output logic [BX_W-1:0]   snap_bx_o,
  output logic              snap_mm_o
);
  logic [WORD_W-1:0]    word_raw;
  fcmd_word_t           word_q;
  logic [DLY_W-1:0]     dly_q [N_CH];
  logic [N_BIT_CMD-1:0] cmd_raw, cmd_d;
  logic                 bx_rst_w, sync_d;
  logic [1:0]           run_q;

  fcmd_ddr_rx #(.HW(HALF_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rise_i(rise_half_i), .fall_i(fall_half_i), .word_o(word_raw)
  );
  assign word_q   = fcmd_word_t'(word_raw);
  assign bx_rst_w = word_q.bx_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) dly_q[i] <= '0;
    end else if (cfg_we_i) begin
      dly_q[cfg_sel_i] <= cfg_dly_i;
    end
  end

  assign cmd_raw = {word_q.evid_rst, word_q.sync, word_q.snap, word_q.nzs,
                    word_q.hdr_only, word_q.fe_rst, word_q.veto};

  for (genvar g = 0; g < N_BIT_CMD; g++) begin : g_dl
    fcmd_delay_line #(.W(1), .DMAX(MAX_DLY)) u_dl (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .d_i(cmd_raw[g]), .sel_i(dly_q[g]), .q_o(cmd_d[g])
    );
  end

  fcmd_delay_line #(.W(CAL_W), .DMAX(MAX_DLY)) u_dl_cal (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i(word_q.cal), .sel_i(dly_q[CH_CAL]), .q_o(cal_type_o)
  );

  assign veto_o     = cmd_d[CH_VETO];
  assign fe_rst_o   = cmd_d[CH_FE];
  assign hdr_only_o = cmd_d[CH_HDR];
  assign nzs_o      = cmd_d[CH_NZS];
  assign snap_o     = cmd_d[CH_SNAP];
  assign evid_rst_o = cmd_d[CH_EVID];
  assign sync_d     = cmd_d[CH_SYNC];

  // persistence filter: act from the third consecutive cycle on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (!sync_d)      run_q <= '0;
    else if (run_q != 2'd2) run_q <= run_q + 1'b1;
  end
  assign sync_o = sync_d && (run_q == 2'd2);

  fcmd_bx_track #(.BX_W(BX_W), .ORBIT_LEN(ORBIT_LEN)) u_bx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_bx_i(word_q.bx), .bx_rst_i(bx_rst_w), .clr_i(clr_mm_i),
    .cnt_o(bx_cnt_o), .mm_o(mismatch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_bx_o <= '0;
      snap_mm_o <= 1'b0;
    end else if (snap_o) begin
      snap_bx_o <= bx_cnt_o;
      snap_mm_o <= mismatch_o;
    end
  end
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk #(
  parameter int unsigned ORBIT_LEN = 3564,
  parameter int unsigned BX_W      = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bx_rst_w,
  input logic            sync_d,
  input logic            sync_o,
  input logic            snap_o,
  input logic            clr_mm_i,
  input logic [BX_W-1:0] bx_cnt_o,
  input logic            mismatch_o,
  input logic [BX_W-1:0] snap_bx_o,
  input logic            snap_mm_o
);
  localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_rst_w |=> bx_cnt_o == (($past(bx_cnt_o) == LAST) ? '0 : $past(bx_cnt_o) + 1'b1));

  a_r6_reload_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_rst_w |=> bx_cnt_o == BX_W'(1));

  a_r7_mm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o && !clr_mm_i |=> mismatch_o);

  a_r8_sync_persist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(sync_d) && $past(sync_d, 2));

  a_r9_snap_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_o |=> snap_bx_o == $past(bx_cnt_o) && snap_mm_o == $past(mismatch_o));
endmodule

bind fcmd_decoder fcmd_decoder_chk #(.ORBIT_LEN(ORBIT_LEN), .BX_W(fcmd_pkg::BX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bx_rst_w(bx_rst_w), .sync_d(sync_d),
  .sync_o(sync_o), .snap_o(snap_o), .clr_mm_i(clr_mm_i), .bx_cnt_o(bx_cnt_o),
  .mismatch_o(mismatch_o), .snap_bx_o(snap_bx_o), .snap_mm_o(snap_mm_o)
);

// File: tb/sim_fcmd_decoder.sv
module sim_fcmd_decoder;
  localparam int ORB  = 40;
  localparam int DMAX = 31;
  localparam int N    = 700;
  localparam int NC   = N + DMAX + 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] rise_half_i = '0, fall_half_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [4:0]  cfg_dly_i = '0;
  logic        clr_mm_i = 1'b0;
  logic        veto_o, fe_rst_o, hdr_only_o, nzs_o, snap_o, evid_rst_o, sync_o, mismatch_o, snap_mm_o;
  logic [3:0]  cal_type_o;
  logic [11:0] bx_cnt_o, snap_bx_o;

  int total = 0, bad = 0;
  logic [23:0] w [N];
  logic        clr_a [NC + 2];
  int          dcfg [8];

  always #10 clk_i = ~clk_i;

  fcmd_decoder #(.ORBIT_LEN(ORB), .MAX_DLY(DMAX)) u0 (
    .clk_i, .rst_ni, .rise_half_i, .fall_half_i, .cfg_we_i, .cfg_sel_i, .cfg_dly_i,
    .clr_mm_i, .veto_o, .fe_rst_o, .hdr_only_o, .nzs_o, .snap_o, .evid_rst_o,
    .cal_type_o, .sync_o, .bx_cnt_o, .mismatch_o, .snap_bx_o, .snap_mm_o
  );

  function automatic logic [23:0] getw(input int i);
    return (i < 0 || i >= N) ? 24'h0 : w[i];
  endfunction

  // channel index -> word bit position (R2)
  function automatic int chpos(input int k);
    case (k)
      0: return 16; 1: return 17; 2: return 19; 3: return 20;
      4: return 21; 5: return 22; default: return 23;
    endcase
  endfunction

  function automatic bit chb(input int idx, input int k);
    logic [23:0] x;
    x = getw(idx);
    return x[chpos(k)];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input int ph);
    int bxg, sleft;
    bxg = 0; sleft = 0;
    for (int t = 0; t < N; t++) begin
      logic [23:0] x;
      x = '0;
      if (t >= 12) begin
        x[16] = ($urandom % 4) == 0;
        x[17] = ($urandom % 16) == 0;
        x[19] = ($urandom % 4) == 0;
        x[20] = ($urandom % 8) == 0;
        x[21] = ($urandom % 10) == 0;
        x[23] = ($urandom % 20) == 0;
        if (($urandom % 8) == 0) x[15:12] = 4'($urandom);
        // directed sync runs of 2, 3 and 1, then random runs
        if (t >= 100 && t < 102) x[22] = 1'b1;
        else if (t >= 120 && t < 123) x[22] = 1'b1;
        else if (t == 140) x[22] = 1'b1;
        else if (t >= 160) begin
          if (sleft == 0 && ($urandom % 20) == 0) sleft = 1 + ($urandom % 5);
          if (sleft > 0) begin x[22] = 1'b1; sleft--; end
        end
        if (t < 20) x[11:0] = 12'($urandom);
        else begin
          if (t == 20) bxg = 0;
          x[11:0] = 12'(bxg);
          x[18]   = (bxg == 0);
          bxg     = (bxg == ORB - 1) ? 0 : bxg + 1;
          if (($urandom % (ph == 0 ? 40 : 20)) == 0) x[11:0] ^= 12'(1 << ($urandom % 12));
        end
      end
      w[t] = x;
    end
    for (int t = 0; t < NC + 2; t++) clr_a[t] = (t >= 16) && (($urandom % 25) == 0);
  endtask

  task automatic run_phase(input int ph);
    int m_cnt, m_mm, m_lock, m_sbx, m_smm;
    build(ph);
    if (ph == 0) dcfg = '{3, 16, 7, 0, 5, 2, 9, 16};
    else         dcfg = '{0, 31, 1, 31, 0, 4, 31, 0};
    rst_ni = 1'b0; rise_half_i = '0; fall_half_i = '0; cfg_we_i = 1'b0; clr_mm_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #5;
    // R10 reset state
    chk("R10 reset strobes", {veto_o, fe_rst_o, hdr_only_o, nzs_o, snap_o, evid_rst_o, sync_o}, 0);
    chk("R10 reset cal", cal_type_o, 0);
    chk("R10 reset cnt", bx_cnt_o, 0);
    chk("R10 reset flags", {mismatch_o, snap_mm_o}, 0);
    chk("R10 reset snap_bx", snap_bx_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_cnt = 0; m_mm = 0; m_lock = 0; m_sbx = 0; m_smm = 0;
    for (int c = 0; c < NC; c++) begin
      logic [23:0] cur, nxt, wp;
      int exp_bx, dsn;
      bit err, bxr, s0, s1, s2;
      @(posedge clk_i);
      #2;
      cur = getw(c); nxt = getw(c + 1);
      fall_half_i = cur[11:0];
      rise_half_i = nxt[23:12];
      cfg_we_i  = (c < 8);
      cfg_sel_i = 3'(c);
      cfg_dly_i = 5'(dcfg[c % 8]);
      clr_mm_i  = clr_a[c + 1];
      #3;
      // model state after this edge
      if (chb(c - 2 - dcfg[4], 4)) begin m_sbx = m_cnt; m_smm = m_mm; end
      wp  = getw(c - 2);
      bxr = wp[18];
      exp_bx = bxr ? 0 : m_cnt;
      err = (m_lock != 0 || bxr) && (int'(wp[11:0]) != exp_bx);
      if (err) m_mm = 1; else if (clr_a[c]) m_mm = 0;
      m_cnt = bxr ? 1 : ((m_cnt == ORB - 1) ? 0 : m_cnt + 1);
      if (bxr) m_lock = 1;
      chk("R2 R3 veto", veto_o, chb(c - 1 - dcfg[0], 0));
      chk("R3 hdr_only", hdr_only_o, chb(c - 1 - dcfg[2], 2));
      chk("R3 nzs", nzs_o, chb(c - 1 - dcfg[3], 3));
      chk("R3 evid_rst", evid_rst_o, chb(c - 1 - dcfg[6], 6));
      chk("R5 fe_rst", fe_rst_o, chb(c - 1 - dcfg[1], 1));
      chk("R9 snap strobe", snap_o, chb(c - 1 - dcfg[4], 4));
      begin
        logic [23:0] cw;
        cw = getw(c - 1 - dcfg[7]);
        chk("R4 cal_type", cal_type_o, cw[15:12]);
      end
      dsn = dcfg[5];
      s0 = chb(c - 1 - dsn, 5); s1 = chb(c - 2 - dsn, 5); s2 = chb(c - 3 - dsn, 5);
      chk("R8 sync", sync_o, s0 && s1 && s2);
      chk("R6 bx_cnt", bx_cnt_o, m_cnt);
      if (fe_rst_o) chk("R5 cnt kept across fe_rst", bx_cnt_o, m_cnt);
      chk("R1 R7 mismatch", mismatch_o, m_mm);
      chk("R9 snap_bx", snap_bx_o, m_sbx);
      chk("R9 snap_mm", snap_mm_o, m_smm);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    run_phase(0);
    run_phase(1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule